// File: doc/BRIEF.md
# Parity Bus Transceiver with Error Register

This block links an 8-bit A bus with a 9-bit B bus. On the B bus, eight data bits travel with one parity bit. Two active-low enables set the direction of transfer.

- **A to B:** the byte passes through unchanged and the block adds an odd-parity bit.
- **B to A:** the byte passes through unchanged and the block checks all nine received bits. A parity failure is captured into an error register on the rising clock edge.
- **Diagnostic mode:** asserting both enables sends data from A to B with the parity bit inverted. This puts a known-bad word on the B bus on purpose.
- **Isolation:** releasing both enables drives neither bus.

Each bus is modelled as separate input, output and drive-enable signals rather than as tristate pins. The error output is active low, in the manner of an open-collector flag. An asynchronous active-low clear resets the error register.

Top module: `parity_xcvr`

## Requirements
- R1: With b_en_n=0 and a_en_n=1, b_oe=1, a_oe=0 and b_out equals a_in, combinationally.
- R2: In the mode of R1, b_par_out is set so that {b_par_out, b_out} holds an odd number of ones.
- R3: With both enables at 0, b_oe=1, a_oe=0, b_out equals a_in and b_par_out is inverted, so that {b_par_out, b_out} holds an even number of ones.
- R4: With a_en_n=0 and b_en_n=1, a_oe=1, b_oe=0 and a_out equals b_in, combinationally.
- R5: With both enables at 1, a_oe=0 and b_oe=0. Undriven outputs read 0.
- R6: At a rising clk edge in the mode of R4, err_n takes the value 0 if {b_par_in, b_in} holds an even number of ones, and 1 if it holds an odd number. err_n holds that value until the next edge.
- R7: At a rising clk edge in any mode other than that of R4, err_n takes the value 1.
- R8: While clr_n=0, err_n is 1 at once and stays 1 across clk edges, whatever the other inputs are.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the error register |
| clr_n | input | 1 | Asynchronous active-low clear of the error register |
| a_en_n | input | 1 | Active-low enable of the A-side drivers |
| b_en_n | input | 1 | Active-low enable of the B-side drivers |
| a_in | input | 8 | Data received from the A bus |
| a_out | output | 8 | Data driven onto the A bus |
| a_oe | output | 1 | A bus drive enable |
| b_in | input | 8 | Data received from the B bus |
| b_par_in | input | 1 | Parity bit received from the B bus |
| b_out | output | 8 | Data driven onto the B bus |
| b_par_out | output | 1 | Parity bit driven onto the B bus |
| b_oe | output | 1 | B bus drive enable |
| err_n | output | 1 | Registered parity error flag, active low |

## Verification
The data outputs, parity outputs and drive enables have no register in their path. They are due in the same cycle as the stimulus, so the monitor compares them 1 ns after the driver changes the inputs on a falling edge. The error flag passes through a single register and is due after the first rising edge that follows the stimulus. The monitor checks it 1 ns after that edge, before the driver applies the next stimulus. The asynchronous clear is checked between clock edges, and again after a clock edge taken while the clear is held low.

// File: rtl/pxcvr_pkg.sv
package pxcvr_pkg;
    typedef enum logic [1:0] {
        MODE_ISOLATE   = 2'd0,
        MODE_A2B       = 2'd1,
        MODE_B2A       = 2'd2,
        MODE_A2B_FORCE = 2'd3
    } xfer_mode_e;

    typedef struct packed {
        logic err;
    } flag_state_t;
endpackage

// File: rtl/pxcvr_mode_dec.sv
module pxcvr_mode_dec
    import pxcvr_pkg::*;
(
    input  logic       a_en_n,
    input  logic       b_en_n,
    output xfer_mode_e mode
);
    always_comb begin
        unique case ({a_en_n, b_en_n})
            2'b10:   mode = MODE_A2B;
            2'b01:   mode = MODE_B2A;
            2'b00:   mode = MODE_A2B_FORCE;
            default: mode = MODE_ISOLATE;
        endcase
    end
endmodule

// File: rtl/pxcvr_parity.sv
module pxcvr_parity #(
    parameter int W = 8
) (
    input  logic [W-1:0] d,
    output logic         odd
);
    logic [W-1:0] chain;
    assign chain[0] = d[0];
    for (genvar i = 1; i < W; i++) begin : g_chain
        assign chain[i] = chain[i-1] ^ d[i];
    end
    assign odd = chain[W-1];
endmodule

// File: rtl/parity_xcvr.sv
module parity_xcvr
    import pxcvr_pkg::*;
#(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          clr_n,
    input  logic          a_en_n,
    input  logic          b_en_n,
    input  logic [DW-1:0] a_in,
    output logic [DW-1:0] a_out,
    output logic          a_oe,
    input  logic [DW-1:0] b_in,
    input  logic          b_par_in,
    output logic [DW-1:0] b_out,
    output logic          b_par_out,
    output logic          b_oe,
    output logic          err_n
);
    localparam int BW = DW + 1;

    xfer_mode_e  mode;
    logic        a_odd;
    logic        b_odd;
    flag_state_t state_d, state_q;

    pxcvr_mode_dec u_dec (
        .a_en_n (a_en_n),
        .b_en_n (b_en_n),
        .mode   (mode)
    );

    pxcvr_parity #(.W(DW)) u_gen (
        .d   (a_in),
        .odd (a_odd)
    );

    pxcvr_parity #(.W(BW)) u_chk (
        .d   ({b_par_in, b_in}),
        .odd (b_odd)
    );

    always_comb begin
        a_out       = '0;
        a_oe        = 1'b0;
        b_out       = '0;
        b_par_out   = 1'b0;
        b_oe        = 1'b0;
        state_d.err = 1'b0;
        unique case (mode)
            MODE_A2B: begin
                b_oe      = 1'b1;
                b_out     = a_in;
                b_par_out = ~a_odd;
            end
            MODE_A2B_FORCE: begin
                b_oe      = 1'b1;
                b_out     = a_in;
                b_par_out = a_odd;
            end
            MODE_B2A: begin
                a_oe        = 1'b1;
                a_out       = b_in;
                state_d.err = ~b_odd;
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk or negedge clr_n) begin
        if (!clr_n) state_q <= '0;
        else        state_q <= state_d;
    end

    assign err_n = ~state_q.err;
endmodule

// File: rtl/pxcvr_chk.sv
module pxcvr_chk #(
    parameter int DW = 8
) (
    input logic          clk,
    input logic          clr_n,
    input logic          a_en_n,
    input logic          b_en_n,
    input logic [DW-1:0] a_in,
    input logic [DW-1:0] a_out,
    input logic          a_oe,
    input logic [DW-1:0] b_in,
    input logic          b_par_in,
    input logic [DW-1:0] b_out,
    input logic          b_par_out,
    input logic          b_oe,
    input logic          err_n
);
    logic a2b, b2a, frc, iso;
    assign a2b = a_en_n && !b_en_n;
    assign b2a = !a_en_n && b_en_n;
    assign frc = !a_en_n && !b_en_n;
    assign iso = a_en_n && b_en_n;

    assert_a2b_drive_R1: assert property (@(posedge clk)
        a2b |-> (b_oe && !a_oe && b_out == a_in));
    assert_odd_parity_R2: assert property (@(posedge clk)
        a2b |-> ($countones({b_par_out, b_out}) % 2 == 1));
    assert_forced_even_R3: assert property (@(posedge clk)
        frc |-> (b_oe && !a_oe && b_out == a_in &&
                 $countones({b_par_out, b_out}) % 2 == 0));
    assert_b2a_drive_R4: assert property (@(posedge clk)
        b2a |-> (a_oe && !b_oe && a_out == b_in));
    assert_isolate_R5: assert property (@(posedge clk)
        iso |-> (!a_oe && !b_oe));
    assert_err_capture_R6: assert property (@(posedge clk) disable iff (!clr_n)
        b2a |=> (err_n == ($countones({$past(b_par_in), $past(b_in)}) % 2 == 1)));
    assert_err_idle_R7: assert property (@(posedge clk) disable iff (!clr_n)
        !b2a |=> err_n);
    assert_clear_R8: assert property (@(posedge clk)
        !clr_n |-> err_n);
endmodule

bind parity_xcvr pxcvr_chk #(.DW(DW)) u_pxcvr_chk (
    .clk(clk), .clr_n(clr_n), .a_en_n(a_en_n), .b_en_n(b_en_n),
    .a_in(a_in), .a_out(a_out), .a_oe(a_oe), .b_in(b_in),
    .b_par_in(b_par_in), .b_out(b_out), .b_par_out(b_par_out),
    .b_oe(b_oe), .err_n(err_n)
);

// File: tb/parity_xcvr_tb.sv
module parity_xcvr_tb;
    localparam int DW = 8;

    logic          clk = 1'b0;
    logic          clr_n = 1'b0;
    logic          a_en_n = 1'b1;
    logic          b_en_n = 1'b1;
    logic [DW-1:0] a_in = '0;
    logic [DW-1:0] b_in = '0;
    logic          b_par_in = 1'b0;
    logic [DW-1:0] a_out, b_out;
    logic          a_oe, b_oe, b_par_out, err_n;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    typedef struct {
        logic [1:0]    mode;
        logic          x_a_oe;
        logic          x_b_oe;
        logic [DW-1:0] x_a_out;
        logic [DW-1:0] x_b_out;
        logic          x_par_odd;
        logic          x_err_n;
    } exp_t;

    exp_t sb[$];

    always #2.5 clk = ~clk;

    parity_xcvr #(.DW(DW)) u_dut (
        .clk(clk), .clr_n(clr_n), .a_en_n(a_en_n), .b_en_n(b_en_n),
        .a_in(a_in), .a_out(a_out), .a_oe(a_oe), .b_in(b_in),
        .b_par_in(b_par_in), .b_out(b_out), .b_par_out(b_par_out),
        .b_oe(b_oe), .err_n(err_n)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
        end
    endtask

    // mode encoding: 1 = A to B, 2 = B to A, 3 = both enables low, 0 = isolate
    task automatic drive(input logic [1:0] mode, input logic [DW-1:0] a,
                         input logic [DW-1:0] b, input logic p);
        exp_t e;
        @(negedge clk);
        a_in = a; b_in = b; b_par_in = p;
        a_en_n = !(mode == 2 || mode == 3);
        b_en_n = !(mode == 1 || mode == 3);
        e.mode      = mode;
        e.x_a_oe    = (mode == 2);
        e.x_b_oe    = (mode == 1 || mode == 3);
        e.x_a_out   = (mode == 2) ? b : '0;
        e.x_b_out   = (mode == 1 || mode == 3) ? a : '0;
        e.x_par_odd = (mode == 1);
        e.x_err_n   = (mode == 2) ? ($countones({p, b}) % 2 == 1) : 1'b1;
        sb.push_back(e);
    endtask

    initial begin : monitor
        exp_t e;
        forever begin
            wait (sb.size() > 0);
            e = sb.pop_front();
            #1;
            case (e.mode)
                2'd1: begin
                    check("R1 b_oe", b_oe, 1'b1);
                    check("R1 a_oe", a_oe, 1'b0);
                    check("R1 b_out", b_out, e.x_b_out);
                    check("R2 parity odd", $countones({b_par_out, b_out}) % 2, 1);
                end
                2'd3: begin
                    check("R3 oe", {a_oe, b_oe}, 2'b01);
                    check("R3 b_out", b_out, e.x_b_out);
                    check("R3 parity even", $countones({b_par_out, b_out}) % 2, 0);
                end
                2'd2: begin
                    check("R4 oe", {a_oe, b_oe}, 2'b10);
                    check("R4 a_out", a_out, e.x_a_out);
                end
                default: begin
                    check("R5 oe", {a_oe, b_oe}, 2'b00);
                    check("R5 outputs zero", {a_out, b_out, b_par_out}, '0);
                end
            endcase
            @(posedge clk);
            #1;
            check(e.mode == 2 ? "R6 err_n" : "R7 err_n", err_n, e.x_err_n);
        end
    end

    initial begin : main
        #1;
        check("R8 reset err_n", err_n, 1'b1);
        @(negedge clk);
        clr_n = 1'b1;
        drive(2'd1, 8'h00, 8'h00, 1'b0);
        drive(2'd1, 8'h01, 8'h00, 1'b0);
        drive(2'd1, 8'hFF, 8'h00, 1'b0);
        drive(2'd3, 8'h00, 8'h00, 1'b0);
        drive(2'd3, 8'hA5, 8'h00, 1'b0);
        drive(2'd0, 8'h3C, 8'h55, 1'b1);
        drive(2'd2, 8'h00, 8'h00, 1'b1);   // odd count: no error
        drive(2'd2, 8'h00, 8'h00, 1'b0);   // even count: error
        drive(2'd2, 8'h00, 8'h00, 1'b0);   // error stays
        drive(2'd0, 8'h00, 8'h00, 1'b0);   // isolate clears flag at edge
        drive(2'd2, 8'h80, 8'h03, 1'b0);   // error
        drive(2'd1, 8'h80, 8'h03, 1'b0);   // A2B clears flag
        drive(2'd2, 8'h7F, 8'hFE, 1'b0);   // 7 ones: no error
        for (int i = 0; i < 200; i++) begin
            drive(2'($urandom_range(0, 3)), 8'($urandom), 8'($urandom), 1'($urandom));
        end
        // asynchronous clear
        drive(2'd2, 8'h00, 8'h0F, 1'b0);   // error captured
        wait (sb.size() == 0);
        @(negedge clk);
        check("R6 err before clear", err_n, 1'b0);
        #0.5;
        clr_n = 1'b0;
        #0.5;
        check("R8 async clear", err_n, 1'b1);
        @(posedge clk);
        #1;
        check("R8 clear holds over edge", err_n, 1'b1);
        @(negedge clk);
        clr_n = 1'b1;
        drive(2'd2, 8'h00, 8'h0F, 1'b0);
        wait (sb.size() == 0);
        @(negedge clk);
        @(negedge clk);
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin : watchdog
        #(200000 * 5);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule